// File: doc/BRIEF.md
# Universal Shift and Storage Register with Synchronous Clear

This block is an eight-bit register that, on every rising clock edge, either keeps its value, shifts one place toward the top bit, shifts one place toward the bottom bit, or loads all eight bits at once. A two-bit mode code selects the operation. During a shift, a dedicated serial input fills the bit position that was vacated.

The register reaches the outside world through one shared eight-bit bidirectional port. Here that port is modelled as three separate signals: a data-in bus, a data-out bus and a single drive-enable bit. An external pad ring or wrapper turns these into real tri-state pins. The port is driven only when both active-low enables are low and the block is not loading. In load mode the drivers are always off, so the port can carry the incoming word.

The lowest and highest bit outputs are driven at all times, so that several registers can be chained end to end. A clear input acts only at the clock edge and wins over every mode. The port is a plain per-cycle interface with no valid/ready handshake. A value is taken on each rising edge, so there is no back-pressure: the user holds the inputs stable across the sampling edge.

Top module: `univ_shreg`

## Requirements
- R1: After the first rising edge with `clr` high, the register (`q_lo`, `q_hi`, and `port_out` when enabled) reads all zeros.
- R2: `clr` takes priority over every mode code, including parallel load (`mode`=2'b11).
- R3: With `mode`=2'b00 (encoding {S1,S0}) and `clr` low, the register keeps its value across the edge.
- R4: With `mode`=2'b01, each edge makes bit i+1 take old bit i, and bit 0 takes `ser_lo`.
- R5: With `mode`=2'b10, each edge makes bit i take old bit i+1, and bit 7 takes `ser_hi`.
- R6: With `mode`=2'b11, each edge loads `port_in[i]` into bit i.
- R7: `port_oe` is 1 exactly when `oe1_n`=0, `oe2_n`=0 and `mode`!=2'b11. When `port_oe` is 1, `port_out` equals the register contents. `port_oe` is never 1 while `mode`=2'b11.
- R8: `q_lo` always equals bit 0 and `q_hi` always equals bit 7, whatever the enables and mode.
- R9: Nothing changes between rising edges. Changes on `clr`, `mode` or the serial inputs take effect only at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, used only to qualify the assertions |
| clr | input | 1 | Synchronous clear, active high |
| mode | input | 2 | {S1,S0} operation select |
| ser_lo | input | 1 | Serial input entering bit 0 on an upward shift |
| ser_hi | input | 1 | Serial input entering bit 7 on a downward shift |
| oe1_n | input | 1 | Output enable 1, active low |
| oe2_n | input | 1 | Output enable 2, active low |
| port_in | input | 8 | Value sensed on the shared port |
| port_out | output | 8 | Value driven onto the shared port |
| port_oe | output | 1 | Drive enable for the shared port |
| q_lo | output | 1 | Bit 0, always driven |
| q_hi | output | 1 | Bit 7, always driven |

## Verification
Random mode codes, serial bits, enables and port words are applied every cycle, with clear pulsed now and then. A model in the bench predicts the contents, and a shift in the wrong direction or with the wrong fill bit shows up as a mismatch. Walking-one shifts in both directions, run until the word is empty, separate the end-bit handling from the interior bit moves. Directed cases put clear together with load and walk through all four enable combinations in each mode, which exposes errors in clear priority and in the enable gating.

// File: rtl/univ_shreg_pkg.sv
package univ_shreg_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_UP    = 2'b01,
    MODE_DOWN  = 2'b10,
    MODE_LOAD  = 2'b11
  } shreg_mode_e;
endpackage

// File: rtl/shreg_next.sv
module shreg_next
  import univ_shreg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  input  logic [1:0]   mode,
  input  logic         clr,
  input  logic         ser_lo,
  input  logic         ser_hi,
  input  logic [W-1:0] par,
  output logic [W-1:0] nxt
);
  logic [W-1:0] up_w, dn_w;

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      if (g == 0) begin : g_lo
        assign up_w[g] = ser_lo;
      end else begin : g_mid_up
        assign up_w[g] = cur[g-1];
      end
      if (g == W-1) begin : g_hi
        assign dn_w[g] = ser_hi;
      end else begin : g_mid_dn
        assign dn_w[g] = cur[g+1];
      end
    end
  endgenerate

  always_comb begin
    if (clr) nxt = '0;
    else begin
      unique case (shreg_mode_e'(mode))
        MODE_HOLD: nxt = cur;
        MODE_UP:   nxt = up_w;
        MODE_DOWN: nxt = dn_w;
        default:   nxt = par;
      endcase
    end
  end
endmodule

// File: rtl/shreg_oe.sv
module shreg_oe (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       oe1_n,
  input  logic       oe2_n,
  output logic       oe
);
  assign oe = ~oe1_n & ~oe2_n & ~(mode[1] & mode[0]);

  assert_oe_off_in_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |-> !oe);
  assert_oe_needs_enables_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> (!oe1_n && !oe2_n));
endmodule

// File: rtl/univ_shreg.sv
module univ_shreg
  import univ_shreg_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [1:0]   mode,
  input  logic         ser_lo,
  input  logic         ser_hi,
  input  logic         oe1_n,
  input  logic         oe2_n,
  input  logic [W-1:0] port_in,
  output logic [W-1:0] port_out,
  output logic         port_oe,
  output logic         q_lo,
  output logic         q_hi
);
  localparam int MSB = W - 1;

  logic [W-1:0] state_q = '0;
  logic [W-1:0] state_d;

  shreg_next #(.W(W)) u_next (
    .cur(state_q), .mode(mode), .clr(clr), .ser_lo(ser_lo),
    .ser_hi(ser_hi), .par(port_in), .nxt(state_d)
  );

  shreg_oe u_oe (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .oe1_n(oe1_n), .oe2_n(oe2_n), .oe(port_oe)
  );

  always_ff @(posedge clk) state_q <= state_d;

  assign port_out = state_q;
  assign q_lo     = state_q[0];
  assign q_hi     = state_q[MSB];

  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= rst_n;

  assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(clr) |-> (port_out == '0));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!clr && mode == 2'b00) |-> $stable(port_out));
  assert_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!clr && mode == 2'b01) |->
      (port_out == {$past(port_out[MSB-1:0]), $past(ser_lo)}));
  assert_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!clr && mode == 2'b10) |->
      (port_out == {$past(ser_hi), $past(port_out[MSB:1])}));
  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(!clr && mode == 2'b11) |-> (port_out == $past(port_in)));
endmodule

// File: tb/test_univ_shreg.sv
module test_univ_shreg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic [1:0] mode = 2'b00;
  logic ser_lo = 1'b0, ser_hi = 1'b0, oe1_n = 1'b1, oe2_n = 1'b1;
  logic [7:0] port_in = '0;
  logic [7:0] port_out;
  logic port_oe, q_lo, q_hi;

  int n_run = 0, n_fail = 0;
  logic [7:0] model = '0;
  bit done = 0;

  always #4 clk = ~clk;

  univ_shreg i_univ_shreg (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mode(mode), .ser_lo(ser_lo),
    .ser_hi(ser_hi), .oe1_n(oe1_n), .oe2_n(oe2_n), .port_in(port_in),
    .port_out(port_out), .port_oe(port_oe), .q_lo(q_lo), .q_hi(q_hi)
  );

  function automatic logic [7:0] next_val(logic [7:0] c, logic cl, logic [1:0] m,
                                          logic sl, logic sh, logic [7:0] p);
    if (cl) return 8'h00;
    case (m)
      2'b00: return c;
      2'b01: return {c[6:0], sl};
      2'b10: return {sh, c[7:1]};
      default: return p;
    endcase
  endfunction

  function automatic logic exp_oe(logic a, logic b, logic [1:0] m);
    return !a && !b && (m != 2'b11);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive inputs at negedge, step one edge, check after it.
  task automatic step(logic cl, logic [1:0] m, logic sl, logic sh,
                      logic a, logic b, logic [7:0] p, string req);
    @(negedge clk);
    clr = cl; mode = m; ser_lo = sl; ser_hi = sh; oe1_n = a; oe2_n = b; port_in = p;
    #1;
    chk("R7 oe", {31'd0, port_oe}, {31'd0, exp_oe(a, b, m)});
    if (m == 2'b11) chk("R7 load never drives", {31'd0, port_oe}, 32'd0);
    chk("R9 no change before edge", {24'd0, port_out}, {24'd0, model});
    model = next_val(model, cl, m, sl, sh, p);
    @(posedge clk); #1;
    chk(req, {24'd0, port_out}, {24'd0, model});
    chk("R8 q_lo", {31'd0, q_lo}, {31'd0, model[0]});
    chk("R8 q_hi", {31'd0, q_hi}, {31'd0, model[7]});
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    step(1, 2'b00, 0, 0, 1, 1, 8'h00, "R1 clear");
    step(0, 2'b11, 0, 0, 0, 0, 8'hA5, "R6 load");
    step(0, 2'b00, 1, 1, 0, 0, 8'hFF, "R3 hold");
    step(1, 2'b11, 0, 0, 0, 0, 8'h3C, "R2 clear beats load");
    step(0, 2'b11, 0, 0, 1, 1, 8'h3C, "R6 load");
    step(1, 2'b01, 1, 1, 0, 0, 8'hFF, "R2 clear beats shift");
    // walking one upward
    step(0, 2'b01, 1, 0, 0, 0, 8'h00, "R4 shift up fill");
    for (int i = 0; i < 8; i++) step(0, 2'b01, 0, 1, 0, 1, 8'hFF, "R4 shift up");
    chk("R4 walked out", {24'd0, port_out}, 32'd0);
    // walking one downward
    step(0, 2'b10, 0, 1, 0, 0, 8'h00, "R5 shift down fill");
    for (int i = 0; i < 8; i++) step(0, 2'b10, 1, 0, 1, 0, 8'hFF, "R5 shift down");
    chk("R5 walked out", {24'd0, port_out}, 32'd0);
    // all enable combos in all modes
    for (int m = 0; m < 4; m++)
      for (int e = 0; e < 4; e++)
        step(0, m[1:0], e[0], e[1], e[0], e[1], 8'h5A ^ 8'(m*17+e), "R3 R4 R5 R6 enable sweep");
    for (int k = 0; k < 2000; k++) begin
      logic [31:0] r;
      r = $urandom;
      step((r[3:0] == 4'd0), r[5:4], r[6], r[7], r[8], r[9], r[17:10], "R4 R5 R6 random");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule